// File: doc/BRIEF.md
# SDRAM Operating-Current Loop Sequencer

This block drives an SDRAM command bus with fixed, repeating command loops used to measure operating supply current. Nothing is requested from outside. Once started, it emits one command per clock from a precomputed slot pattern. In single-bank mode one bank cycles through activate, read and precharge at the minimum row-cycle time. In four-bank mode activates rotate across banks 0 to 3, spaced two clocks apart, and each bank's read follows its activate by three clocks with auto-precharge.

The row-cycle, activate-to-read and activate-to-precharge spacings of the single-bank loop are held as clock counts in a small configuration set. This set can be written only while the sequencer is idle. Each loop takes a fresh pseudo-random address from an LFSR. A write-data register flips half of its bits once per burst.

In single-bank mode the address lines are made to toggle even during NOP slots. In four-bank mode they are held still during NOP slots, so the two modes stress the address pins differently.

Top module: `idd_loop_seq`

## Requirements
- R1: While reset is low and after it is released, until a start: busy_o=0, cmd_o=3'b111 (NOP), bank_o=0, addr_o=0, wdata_o=0, bl4_o=0.
- R2: Suppose start_i is high at a clock edge while the block is idle. From the next cycle busy_o=1, slot 0 begins with an activate, and mode_i (0 = single-bank, 1 = four-bank) is latched for the run.
- R3: In single-bank mode the command codes are {RAS_n,CAS_n,WE_n}: activate 011, read 101, precharge 010, NOP 111. Within a loop of trc slots, slot 0 is an activate, slot trcd is a read, slot tras is a precharge, and every other slot is a NOP. Every command goes to bank 0.
- R4: A four-bank loop has 10 slots in the order A0 N A1 R0 A2 R1 A3 R2 N R3. Every read in this mode has addr_o bit 10 high (auto-precharge).
- R5: In single-bank mode an activate drives the loop address L. A read or precharge drives L with bit 10 cleared. Every NOP slot drives the bitwise inverse of the previous cycle's addr_o.
- R6: In four-bank mode an activate drives L and a read drives L with bit 10 set. A NOP slot repeats the previous cycle's addr_o and bank_o.
- R7: After reset, L starts at 13'h1ACE. L advances once at the end of every loop, to {L[11:0], L[12]^L[3]^L[2]^L[0]}.
- R8: wdata_o becomes wdata_o ^ 16'h5555 in the cycle after each read, and it does not change in any other cycle.
- R9: A loop always runs to its last slot. If start_i is low at that slot's clock edge, the block goes idle (busy_o=0). While idle, cmd_o is NOP and addr_o and bank_o hold their last values. Otherwise the next loop starts.
- R10: A configuration write (cfg_we_i) loads trcd, tras, trc and the burst-length select only when the block is idle and 1 <= trcd < tras < trc. Any other write is ignored. The reset values are trcd=2, tras=5, trc=10 and burst length 2.
- R11: bl4_o shows the loaded burst-length select (1 = burst of 4, 0 = burst of 2) from the cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request; sampled idle to start, at each loop end to continue |
| mode_i | input | 1 | 0 single-bank, 1 four-bank; latched at start |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_trcd_i | input | 5 | Activate-to-read clocks |
| cfg_tras_i | input | 5 | Activate-to-precharge clocks |
| cfg_trc_i | input | 5 | Activate-to-activate clocks (loop length) |
| cfg_bl4_i | input | 1 | Burst length select, 1 = four |
| busy_o | output | 1 | A loop is running |
| bl4_o | output | 1 | Loaded burst length select |
| cmd_o | output | 3 | {RAS_n, CAS_n, WE_n} |
| bank_o | output | 2 | Bank number |
| addr_o | output | 13 | Row/column address |
| wdata_o | output | 16 | Write data pattern |

## Verification
Several rules are checked by assertions on every cycle:
- idle cycles carry only NOPs;
- NOP slots invert the address in single-bank mode and hold the address and bank in four-bank mode;
- the auto-precharge bit is correct on reads in each mode;
- activates in four-bank mode are never back to back;
- the data pattern changes only after a read, and then by exactly the half mask.

Other behaviour shows only in the bench scenarios. This covers the slot positions of each command for each timing set, the LFSR sequence seen at successive activates, and whether a stop request takes effect at a loop boundary. It also covers whether configuration writes made while running or with inconsistent values are rejected. The bench observes that from the measured activate spacing.

// File: rtl/idd_loop_pkg.sv
package idd_loop_pkg;
  typedef enum logic [2:0] {K_NOP, K_ACT, K_RD, K_RDA, K_PRE} kind_e;

  localparam logic [2:0] CMD_ACT = 3'b011;
  localparam logic [2:0] CMD_RD  = 3'b101;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_NOP = 3'b111;

  // alternating ones: half of any even width
  localparam logic [63:0] ALT_MASK64 = 64'h5555_5555_5555_5555;

  function automatic logic [2:0] kind_to_cmd(kind_e k);
    case (k)
      K_ACT:        return CMD_ACT;
      K_RD, K_RDA:  return CMD_RD;
      K_PRE:        return CMD_PRE;
      default:      return CMD_NOP;
    endcase
  endfunction
endpackage

// File: rtl/idd_loop_cfg.sv
module idd_loop_cfg #(
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned DEF_TRCD = 2,
  parameter int unsigned DEF_TRAS = 5,
  parameter int unsigned DEF_TRC  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             idle_i,
  input  logic [CNT_W-1:0] trcd_i,
  input  logic [CNT_W-1:0] tras_i,
  input  logic [CNT_W-1:0] trc_i,
  input  logic             bl4_i,
  output logic [CNT_W-1:0] trcd_o,
  output logic [CNT_W-1:0] tras_o,
  output logic [CNT_W-1:0] trc_o,
  output logic             bl4_o
);
  logic valid;

  assign valid = (trcd_i != '0) && (trcd_i < tras_i) && (tras_i < trc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trcd_o <= CNT_W'(DEF_TRCD);
      tras_o <= CNT_W'(DEF_TRAS);
      trc_o  <= CNT_W'(DEF_TRC);
      bl4_o  <= 1'b0;
    end else if (we_i && idle_i && valid) begin
      trcd_o <= trcd_i;
      tras_o <= tras_i;
      trc_o  <= trc_i;
      bl4_o  <= bl4_i;
    end
  end
endmodule

// File: rtl/idd_loop_lfsr.sv
module idd_loop_lfsr #(
  parameter int unsigned W      = 13,
  parameter logic [W-1:0] TAPS  = 13'h100D,
  parameter logic [W-1:0] SEED  = 13'h1ACE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic fb;

  assign fb = ^(state_o & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_o <= SEED;
    else if (step_i) state_o <= {state_o[W-2:0], fb};
  end
endmodule

// File: rtl/idd_loop_slot.sv
module idd_loop_slot
  import idd_loop_pkg::*;
#(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned NBANK  = 4,
  parameter int unsigned RRD    = 2,
  parameter int unsigned TRCD4  = 3
) (
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  slot_i,
  input  logic [CNT_W-1:0]  trcd_i,
  input  logic [CNT_W-1:0]  tras_i,
  output kind_e             kind_o,
  output logic [BANK_W-1:0] bank_o
);
  always_comb begin
    kind_o = K_NOP;
    bank_o = '0;
    if (!mode_i) begin
      if (slot_i == '0)          kind_o = K_ACT;
      else if (slot_i == trcd_i) kind_o = K_RD;
      else if (slot_i == tras_i) kind_o = K_PRE;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (slot_i == CNT_W'(b * RRD)) begin
          kind_o = K_ACT;
          bank_o = BANK_W'(b);
        end
        if (slot_i == CNT_W'(b * RRD + TRCD4)) begin
          kind_o = K_RDA;
          bank_o = BANK_W'(b);
        end
      end
    end
  end
endmodule

// File: rtl/idd_loop_seq.sv
module idd_loop_seq
  import idd_loop_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned NBANK     = 4,
  parameter int unsigned RRD       = 2,
  parameter int unsigned TRCD4     = 3,
  parameter logic [ADDR_W-1:0] LFSR_TAPS = 13'h100D,
  parameter logic [ADDR_W-1:0] LFSR_SEED = 13'h1ACE,
  parameter logic [DATA_W-1:0] DATA_SEED = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              cfg_we_i,
  input  logic [CNT_W-1:0]  cfg_trcd_i,
  input  logic [CNT_W-1:0]  cfg_tras_i,
  input  logic [CNT_W-1:0]  cfg_trc_i,
  input  logic              cfg_bl4_i,
  output logic              busy_o,
  output logic              bl4_o,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int unsigned FOUR_LEN = (NBANK - 1) * RRD + TRCD4 + 1;
  localparam logic [ADDR_W-1:0] AP_MASK   = ADDR_W'(1) << AP_BIT;
  localparam logic [DATA_W-1:0] DATA_MASK = DATA_W'(ALT_MASK64);

  logic              busy_q, mode_q;
  logic [CNT_W-1:0]  slot_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [BANK_W-1:0] last_bank_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  trcd, tras, trc;
  logic [ADDR_W-1:0] loop_addr;
  logic [BANK_W-1:0] slot_bank;
  kind_e             slot_kind, kind;
  logic              loop_last;

  idd_loop_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idle_i (!busy_q),
    .trcd_i (cfg_trcd_i),
    .tras_i (cfg_tras_i),
    .trc_i  (cfg_trc_i),
    .bl4_i  (cfg_bl4_i),
    .trcd_o (trcd),
    .tras_o (tras),
    .trc_o  (trc),
    .bl4_o  (bl4_o)
  );

  idd_loop_lfsr #(.W(ADDR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (busy_q && loop_last),
    .state_o (loop_addr)
  );

  idd_loop_slot #(
    .CNT_W(CNT_W), .BANK_W(BANK_W), .NBANK(NBANK), .RRD(RRD), .TRCD4(TRCD4)
  ) u_slot (
    .mode_i (mode_q),
    .slot_i (slot_q),
    .trcd_i (trcd),
    .tras_i (tras),
    .kind_o (slot_kind),
    .bank_o (slot_bank)
  );

  assign loop_last = mode_q ? (slot_q == CNT_W'(FOUR_LEN - 1))
                            : (slot_q == trc - CNT_W'(1));
  assign kind      = busy_q ? slot_kind : K_NOP;
  assign cmd_o     = kind_to_cmd(kind);
  assign busy_o    = busy_q;
  assign wdata_o   = data_q;

  always_comb begin
    bank_o = slot_bank;
    unique case (kind)
      K_ACT:        addr_o = loop_addr;
      K_RD, K_PRE:  addr_o = loop_addr & ~AP_MASK;
      K_RDA:        addr_o = loop_addr | AP_MASK;
      default: begin
        // single-bank NOPs toggle the pins, otherwise hold
        addr_o = (busy_q && !mode_q) ? ~last_addr_q : last_addr_q;
        bank_o = last_bank_q;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      mode_q      <= 1'b0;
      slot_q      <= '0;
      last_addr_q <= '0;
      last_bank_q <= '0;
      data_q      <= DATA_SEED;
    end else begin
      last_addr_q <= addr_o;
      last_bank_q <= bank_o;
      if (kind == K_RD || kind == K_RDA) data_q <= data_q ^ DATA_MASK;
      if (busy_q) begin
        if (loop_last) begin
          slot_q <= '0;
          busy_q <= start_i;
        end else begin
          slot_q <= slot_q + CNT_W'(1);
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        slot_q <= '0;
        mode_q <= mode_i;
      end
    end
  end
endmodule

// File: rtl/idd_loop_seq_chk.sv
module idd_loop_seq_chk
  import idd_loop_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned AP_BIT = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              run_mode_i,
  input logic [2:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i
);
  localparam logic [DATA_W-1:0] DATA_MASK = DATA_W'(ALT_MASK64);

  // R1
  idle_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> cmd_i == CMD_NOP);

  // R5
  single_nop_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) && !run_mode_i && cmd_i == CMD_NOP
      |-> addr_i == ~$past(addr_i));

  // R5
  single_no_ap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !run_mode_i && (cmd_i == CMD_RD || cmd_i == CMD_PRE) |-> !addr_i[AP_BIT]);

  // R3
  single_bank0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !run_mode_i && cmd_i != CMD_NOP |-> bank_i == '0);

  // R6
  four_nop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && run_mode_i && cmd_i == CMD_NOP |-> $stable(addr_i) && $stable(bank_i));

  // R4
  four_read_ap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && run_mode_i && cmd_i == CMD_RD |-> addr_i[AP_BIT]);

  // R4
  four_act_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && run_mode_i && cmd_i == CMD_ACT |=> cmd_i != CMD_ACT);

  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i != CMD_RD |=> $stable(wdata_i));

  // R8
  data_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_RD |=> wdata_i == ($past(wdata_i) ^ DATA_MASK));
endmodule

bind idd_loop_seq idd_loop_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_o),
  .run_mode_i (mode_q),
  .cmd_i      (cmd_o),
  .bank_i     (bank_o),
  .addr_i     (addr_o),
  .wdata_i    (wdata_o)
);

// File: tb/idd_loop_seq_test.sv
module idd_loop_seq_test;
  localparam logic [12:0] SEED = 13'h1ACE;
  localparam logic [15:0] MASK = 16'h5555;

  logic        clk, rst_ni;
  logic        start, mode, cfg_we, cfg_bl4;
  logic [4:0]  cfg_trcd, cfg_tras, cfg_trc;
  logic        busy, bl4;
  logic [2:0]  cmd;
  logic [1:0]  bank;
  logic [12:0] addr;
  logic [15:0] wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_en = 0;

  idd_loop_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .mode_i(mode),
    .cfg_we_i(cfg_we), .cfg_trcd_i(cfg_trcd), .cfg_tras_i(cfg_tras),
    .cfg_trc_i(cfg_trc), .cfg_bl4_i(cfg_bl4), .busy_o(busy), .bl4_o(bl4),
    .cmd_o(cmd), .bank_o(bank), .addr_o(addr), .wdata_o(wdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model state
  logic        m_busy, m_mode, m_bl4;
  int          m_slot, m_trcd, m_tras, m_trc;
  logic [12:0] m_lfsr, m_last_addr;
  logic [1:0]  m_last_bank;
  logic [15:0] m_data;
  int          e_kind;
  logic [1:0]  e_bank;
  logic [12:0] e_addr;
  logic [2:0]  e_cmd;

  function automatic logic [12:0] lfsr_next(logic [12:0] s);
    return {s[11:0], s[12] ^ s[3] ^ s[2] ^ s[0]};
  endfunction

  // kinds: 0 nop, 1 act, 2 read, 3 read+ap, 4 precharge
  always_comb begin
    int b;
    e_kind = 0;
    b = 0;
    if (m_busy) begin
      if (!m_mode) begin
        if (m_slot == 0)           e_kind = 1;
        else if (m_slot == m_trcd) e_kind = 2;
        else if (m_slot == m_tras) e_kind = 4;
      end else begin
        if (m_slot % 2 == 0 && m_slot <= 6) begin e_kind = 1; b = m_slot / 2; end
        if (m_slot >= 3 && m_slot % 2 == 1) begin e_kind = 3; b = (m_slot - 3) / 2; end
      end
    end
    case (e_kind)
      1: begin e_addr = m_lfsr; e_cmd = 3'b011; end
      2: begin e_addr = m_lfsr & ~13'h400; e_cmd = 3'b101; end
      3: begin e_addr = m_lfsr | 13'h400; e_cmd = 3'b101; end
      4: begin e_addr = m_lfsr & ~13'h400; e_cmd = 3'b010; end
      default: begin
        e_addr = (m_busy && !m_mode) ? ~m_last_addr : m_last_addr;
        e_cmd  = 3'b111;
      end
    endcase
    e_bank = (e_kind == 0) ? m_last_bank : 2'(b);
  end

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy <= 0; m_mode <= 0; m_slot <= 0;
      m_trcd <= 2; m_tras <= 5; m_trc <= 10; m_bl4 <= 0;
      m_lfsr <= SEED; m_data <= '0; m_last_addr <= '0; m_last_bank <= '0;
    end else begin
      m_last_addr <= e_addr;
      m_last_bank <= e_bank;
      if (e_kind == 2 || e_kind == 3) m_data <= m_data ^ MASK;
      if (m_busy) begin
        if (m_slot == (m_mode ? 10 : m_trc) - 1) begin
          m_lfsr <= lfsr_next(m_lfsr);
          m_slot <= 0;
          m_busy <= start;
        end else m_slot <= m_slot + 1;
      end else if (start) begin
        m_busy <= 1; m_slot <= 0; m_mode <= mode;
      end
      if (cfg_we && !m_busy && cfg_trcd != 0 && cfg_trcd < cfg_tras && cfg_tras < cfg_trc) begin
        m_trcd <= int'(cfg_trcd); m_tras <= int'(cfg_tras); m_trc <= int'(cfg_trc);
        m_bl4 <= cfg_bl4;
      end
    end
  end

  function automatic void check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && chk_en) begin
      check(busy == m_busy, "R9", "busy", 32'(busy), 32'(m_busy));
      check(cmd == e_cmd, m_mode ? "R4" : "R3", "cmd", 32'(cmd), 32'(e_cmd));
      check(bank == e_bank, m_mode ? "R6" : "R3", "bank", 32'(bank), 32'(e_bank));
      check(addr == e_addr, e_kind == 1 ? "R7" : (m_mode ? "R6" : "R5"), "addr",
            32'(addr), 32'(e_addr));
      check(wdata == m_data, "R8", "wdata", 32'(wdata), 32'(m_data));
      check(bl4 == m_bl4, "R11", "bl4", 32'(bl4), 32'(m_bl4));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg_write(int trcd, int tras, int trc, bit b4);
    cfg_we = 1; cfg_trcd = 5'(trcd); cfg_tras = 5'(tras); cfg_trc = 5'(trc); cfg_bl4 = b4;
    tick();
    cfg_we = 0;
  endtask

  task automatic begin_run(bit md);
    start = 1; mode = md;
    tick();
    // R2: first running cycle is an activate
    check(busy == 1'b1 && cmd == 3'b011, "R2", "start", {29'd0, busy, cmd[1:0]}, 32'h7);
  endtask

  task automatic end_run();
    start = 0;
    while (busy) tick();
    repeat (2) tick();
    check(cmd == 3'b111, "R9", "idle cmd", 32'(cmd), 32'h7);
  endtask

  task automatic act_gap(output int gap);
    while (cmd != 3'b011) tick();
    gap = 0;
    do begin tick(); gap++; end while (cmd != 3'b011 && gap < 64);
  endtask

  initial begin
    int gap;
    void'($urandom(32'd1234));
    rst_ni = 0; start = 0; mode = 0; cfg_we = 0;
    cfg_trcd = '0; cfg_tras = '0; cfg_trc = '0; cfg_bl4 = 0;
    repeat (3) tick();
    check(busy == 0 && cmd == 3'b111 && addr == 0 && bank == 0 && wdata == 0,
          "R1", "in reset", {busy, cmd, bank, addr, wdata[8:0]}, 32'h7 << 24);
    rst_ni = 1;
    tick();
    check(busy == 0 && cmd == 3'b111 && addr == 0 && wdata == 0 && bl4 == 0,
          "R1", "after reset", {busy, cmd, addr, wdata[14:0]}, 32'h7 << 28);
    chk_en = 1;

    // inconsistent write is ignored: loop stays at trc=10
    cfg_write(4, 3, 9, 1);
    begin_run(0);
    act_gap(gap);
    check(gap == 10, "R10", "default trc gap", 32'(gap), 32'd10);
    act_gap(gap);
    check(gap == 10, "R3", "trc gap", 32'(gap), 32'd10);
    end_run();

    cfg_write(3, 5, 9, 1);
    check(bl4 == 1'b1, "R11", "bl4 loaded", 32'(bl4), 32'd1);
    begin_run(0);
    repeat (4) tick();
    cfg_write(3, 8, 11, 0);   // busy: ignored
    act_gap(gap);
    check(gap == 9, "R10", "write while busy ignored", 32'(gap), 32'd9);
    end_run();

    begin_run(1);
    repeat (35) tick();
    end_run();

    for (int i = 0; i < 30; i++) begin
      int sel;
      sel = int'($urandom % 4);
      case (sel)
        0: cfg_write(2, 5, 10, 0);
        1: cfg_write(3, 5, 9, 1);
        2: cfg_write(3, 7, 10, 1);
        default: cfg_write(3, 8, 11, 1);
      endcase
      begin_run(1'($urandom % 2));
      for (int j = 0; j < int'($urandom_range(3, 40)); j++) begin
        if ($urandom % 8 == 0) begin
          cfg_write(int'($urandom % 6), int'($urandom % 12), int'($urandom % 16), 1'($urandom % 2));
        end else tick();
      end
      end_run();
      repeat (int'($urandom % 3)) tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule